// File: doc/BRIEF.md
# Burst Cache Line Fill Controller

This block sits between a cache and the external bus and fills one cache line of four 32-bit entries with a burst read when the cache reports a miss. A miss request carries the byte address, the operand length in bytes and a flag telling whether the access is an instruction fetch or a data access. The controller runs the beats in wraparound order. The first beat is the entry that holds the requested operand. Each returned longword either goes into the line with its valid bit set, or is kept out of the line. The longword or longwords that make up the requested operand are forwarded to the requester.

The burst can end early in several ways, and each has its own rule. The cache-inhibit input can be raised. The burst acknowledge can drop. A bus error can arrive on the first beat, or on a later beat. These rules decide what is loaded, what is invalidated, whether an error is reported at once or only recorded as pending, and whether a separate single read is needed to fetch the rest of an operand that crosses a longword boundary.

Top module: `burst_fill_ctrl`

## Requirements
- R1: After reset the block is idle: `miss_ready` is 1, and `bus_rd`, `burst_req`, `fwd_valid`, `err_now`, `err_pend`, `fill_done` and all four bits of `line_valid` are 0.
- R2: A fill reads the line in wraparound order starting at entry `miss_addr[3:2]`, driving `bus_addr = {miss_addr[31:4], entry, 2'b00}`. The address is held until the beat ends. `burst_req` is 1 on the first three beats and 0 on the fourth.
- R3: A beat that ends with `bus_term` and without inhibit or error writes its longword into entry `bus_addr[3:2]` and sets that valid bit. The longword holding the first operand byte is forwarded with `fwd_part` 0. The longword holding the remainder of an operand that crosses a longword boundary is forwarded with `fwd_part` 1. Forwarding happens one cycle after the beat ends.
- R4: If `burst_ack` is 0 when a beat ends, that beat is still loaded, `burst_req` is 0 in the following cycle, and no further burst beat is run.
- R5: Cache-inhibit on the first beat forwards the data but writes nothing into the line and ends the burst.
- R6: Cache-inhibit on a later beat leaves that entry unwritten and ends the burst. The data is still forwarded if that beat holds the operand remainder.
- R7: A bus error on the first beat discards the data, leaves all four valid bits 0 and ends the fill with no further read. A data access pulses `err_now`. An instruction fetch pulses `err_pend`. The two are never both 1.
- R8: A bus error on a later beat leaves that entry invalid, ends the burst, forwards nothing from that beat and raises no error flag.
- R9: When the burst ends and the operand remainder was not obtained, one single read is issued at the next longword address with `burst_req` 0. Its data is forwarded with `fwd_part` 1 and is not written into the line. This also applies when the operand starts in entry 3, and then the read goes to the next line.
- R10: A bus error on that single read pulses `err_now` for a data access or `err_pend` for an instruction fetch.
- R11: `miss_ready` is 0 while a fill is in progress. `fill_done` pulses for one cycle, one cycle after the final read ends, and the block is then ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request, accepted when `miss_ready` is 1 |
| miss_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| miss_addr | input | 32 | Byte address of the requested operand |
| miss_len | input | 3 | Operand length in bytes, 1 to 4 |
| miss_ready | output | 1 | Block idle and able to accept a miss |
| bus_addr | output | 32 | Longword address of the current read |
| bus_rd | output | 1 | A read cycle is in progress |
| burst_req | output | 1 | Request to continue as a burst |
| bus_data | input | 32 | Read data, sampled when the beat ends |
| bus_term | input | 1 | Normal termination of the current read |
| burst_ack | input | 1 | Bus agrees to continue the burst |
| cache_inh | input | 1 | Returned data must not be cached |
| bus_err | input | 1 | Bus error on the current read, takes priority over `bus_term` |
| fwd_valid | output | 1 | Forwarded operand longword is valid |
| fwd_part | output | 1 | 0 for the first part of the operand, 1 for the remainder |
| fwd_data | output | 32 | Forwarded longword |
| err_now | output | 1 | Pulse: bus error to be handled at once |
| err_pend | output | 1 | Pulse: bus error recorded as pending |
| fill_done | output | 1 | Pulse: the fill is complete |
| line_valid | output | 4 | Valid bit of each line entry |
| line_data | output | 128 | Line entries, entry n at bits 32n+31 to 32n |

## Verification
The bench targets four kinds of case. The first is the boundary between first-beat and later-beat faults: a design that mixes them up reports an error for a discarded later beat, or keeps valid entries after a first-beat error. The second is operands that cross a longword boundary, including one that starts in the last entry. A faulty design would skip the single follow-up read, issue it with the burst request still high, issue it after a first-beat error, or write its data into the line. The third is early acknowledge loss and inhibit on the beat that holds the operand remainder; a wrong design would drop the data, cache inhibited data, or run extra beats. The fourth is a retry that errors, which a wrong design would report on the wrong flag or not at all.

// File: rtl/lfc_pkg.sv
`timescale 1ns/1ps
package lfc_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WORD_BYTES = WORD_W / 8;
    localparam int unsigned OFFS_W     = $clog2(WORD_BYTES);
    localparam int unsigned LEN_W      = OFFS_W + 1;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_BURST,
        FS_SINGLE
    } fill_state_e;

    // Per-beat decision produced by the beat evaluator
    typedef struct packed {
        logic keep;         // load the longword into the line
        logic drop_one;     // clear the valid bit of this entry
        logic drop_all;     // clear the whole line
        logic forward;      // hand the longword to the requester
        logic fwd_second;   // forwarded longword is the operand remainder
        logic raise_now;    // immediate bus error
        logic raise_pend;   // pending bus error
        logic proceed;      // run another burst beat
        logic second_seen;  // operand remainder obtained by this beat
    } beat_verdict_t;

    function automatic logic crosses_word(input logic [OFFS_W-1:0] offs,
                                          input logic [LEN_W-1:0]  len);
        logic [LEN_W:0] reach;
        reach = {2'b00, offs} + {1'b0, len};
        return reach > (LEN_W+1)'(WORD_BYTES);
    endfunction

endpackage

// File: rtl/lfc_beat_eval.sv
`timescale 1ns/1ps
module lfc_beat_eval
    import lfc_pkg::*;
(
    input  logic          first_beat,
    input  logic          last_beat,
    input  logic          is_fetch,
    input  logic          has_first,
    input  logic          has_second,
    input  logic          ack,
    input  logic          inhibit,
    input  logic          fault,
    output beat_verdict_t verdict
);

    // Precedence: bus error, then cache inhibit, then acknowledge
    always_comb begin
        verdict = '0;
        if (fault) begin
            verdict.drop_all   = first_beat;
            verdict.drop_one   = !first_beat;
            verdict.raise_now  = first_beat && !is_fetch;
            verdict.raise_pend = first_beat && is_fetch;
        end else begin
            verdict.forward     = has_first || has_second;
            verdict.fwd_second  = has_second && !has_first;
            verdict.second_seen = has_second;
            if (!inhibit) begin
                verdict.keep    = 1'b1;
                verdict.proceed = ack && !last_beat;
            end
        end
    end

endmodule

// File: rtl/lfc_line_store.sv
`timescale 1ns/1ps
module lfc_line_store
    import lfc_pkg::*;
#(
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear_all,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [WORD_W-1:0]         wr_word,
    input  logic                      kill_en,
    input  logic [IDX_W-1:0]          kill_idx,
    output logic [ENTRIES-1:0]        valid,
    output logic [ENTRIES*WORD_W-1:0] words
);

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
            logic              vld_q;
            logic [WORD_W-1:0] word_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q  <= 1'b0;
                    word_q <= '0;
                end else if (clear_all) begin
                    vld_q <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                    vld_q  <= 1'b1;
                    word_q <= wr_word;
                end else if (kill_en && (kill_idx == IDX_W'(e))) begin
                    vld_q <= 1'b0;
                end
            end

            assign valid[e]                    = vld_q;
            assign words[e*WORD_W +: WORD_W]   = word_q;
        end
    endgenerate

endmodule

// File: rtl/lfc_seq.sv
`timescale 1ns/1ps
module lfc_seq
    import lfc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 4,
    parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic              miss_instr,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [LEN_W-1:0]  miss_len,
    output logic              miss_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              burst_req,
    input  logic [WORD_W-1:0] bus_data,
    input  logic              bus_term,
    input  logic              bus_err,
    output logic              first_beat,
    output logic              last_beat,
    output logic              is_fetch,
    output logic              has_first,
    output logic              has_second,
    input  beat_verdict_t     verdict,
    output logic              st_clear,
    output logic              st_wr,
    output logic              st_kill,
    output logic [IDX_W-1:0]  st_idx,
    output logic              fwd_valid,
    output logic              fwd_part,
    output logic [WORD_W-1:0] fwd_data,
    output logic              err_now,
    output logic              err_pend,
    output logic              fill_done
);

    localparam int unsigned TAG_LSB = OFFS_W + IDX_W;
    localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;
    localparam int unsigned WADDR_W = ADDR_W - OFFS_W;
    localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(ENTRIES - 1);

    fill_state_e        st_q;
    logic [TAG_W-1:0]   tag_q;
    logic [IDX_W-1:0]   start_q;
    logic [IDX_W-1:0]   count_q;
    logic [IDX_W-1:0]   cur_idx;
    logic               fetch_q;
    logic               split_q;
    logic               second_q;
    logic [WADDR_W-1:0] spill_q;
    logic               accept;
    logic               beat_end;
    logic               in_burst;
    logic               more_needed;

    assign cur_idx  = start_q + count_q;
    assign in_burst = (st_q == FS_BURST);
    assign accept   = miss_valid && (st_q == FS_IDLE);
    assign beat_end = (st_q != FS_IDLE) && (bus_term || bus_err);

    assign miss_ready = (st_q == FS_IDLE);
    assign bus_rd     = (st_q != FS_IDLE);
    assign burst_req  = in_burst && (count_q != LAST_CNT);
    assign bus_addr   = (st_q == FS_SINGLE) ? {spill_q, {OFFS_W{1'b0}}}
                                            : {tag_q, cur_idx, {OFFS_W{1'b0}}};

    // Beat context for the evaluator
    assign first_beat = (count_q == '0);
    assign last_beat  = (count_q == LAST_CNT);
    assign is_fetch   = fetch_q;
    assign has_first  = first_beat;
    assign has_second = split_q && (start_q != TOP_IDX) && (count_q == IDX_W'(1));

    // Line store controls
    assign st_clear = accept || (in_burst && beat_end && verdict.drop_all);
    assign st_wr    = in_burst && beat_end && verdict.keep;
    assign st_kill  = in_burst && beat_end && verdict.drop_one;
    assign st_idx   = cur_idx;

    assign more_needed = split_q && !second_q && !verdict.second_seen && !verdict.drop_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= FS_IDLE;
            tag_q     <= '0;
            start_q   <= '0;
            count_q   <= '0;
            fetch_q   <= 1'b0;
            split_q   <= 1'b0;
            second_q  <= 1'b0;
            spill_q   <= '0;
            fwd_valid <= 1'b0;
            fwd_part  <= 1'b0;
            fwd_data  <= '0;
            err_now   <= 1'b0;
            err_pend  <= 1'b0;
            fill_done <= 1'b0;
        end else begin
            fwd_valid <= 1'b0;
            err_now   <= 1'b0;
            err_pend  <= 1'b0;
            fill_done <= 1'b0;
            case (st_q)
                FS_IDLE: begin
                    if (accept) begin
                        tag_q    <= miss_addr[ADDR_W-1:TAG_LSB];
                        start_q  <= miss_addr[TAG_LSB-1:OFFS_W];
                        count_q  <= '0;
                        fetch_q  <= miss_instr;
                        split_q  <= crosses_word(miss_addr[OFFS_W-1:0], miss_len);
                        second_q <= 1'b0;
                        spill_q  <= miss_addr[ADDR_W-1:OFFS_W] + WADDR_W'(1);
                        st_q     <= FS_BURST;
                    end
                end
                FS_BURST: begin
                    if (beat_end) begin
                        fwd_valid <= verdict.forward;
                        fwd_part  <= verdict.fwd_second;
                        fwd_data  <= bus_data;
                        err_now   <= verdict.raise_now;
                        err_pend  <= verdict.raise_pend;
                        if (verdict.second_seen) begin
                            second_q <= 1'b1;
                        end
                        if (verdict.proceed) begin
                            count_q <= count_q + IDX_W'(1);
                        end else if (more_needed) begin
                            st_q <= FS_SINGLE;
                        end else begin
                            st_q      <= FS_IDLE;
                            fill_done <= 1'b1;
                        end
                    end
                end
                FS_SINGLE: begin
                    if (beat_end) begin
                        fwd_valid <= !bus_err;
                        fwd_part  <= 1'b1;
                        fwd_data  <= bus_data;
                        err_now   <= bus_err && !fetch_q;
                        err_pend  <= bus_err && fetch_q;
                        st_q      <= FS_IDLE;
                        fill_done <= 1'b1;
                    end
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/burst_fill_ctrl.sv
`timescale 1ns/1ps
module burst_fill_ctrl
    import lfc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      miss_valid,
    input  logic                      miss_instr,
    input  logic [ADDR_W-1:0]         miss_addr,
    input  logic [LEN_W-1:0]          miss_len,
    output logic                      miss_ready,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic                      bus_rd,
    output logic                      burst_req,
    input  logic [WORD_W-1:0]         bus_data,
    input  logic                      bus_term,
    input  logic                      burst_ack,
    input  logic                      cache_inh,
    input  logic                      bus_err,
    output logic                      fwd_valid,
    output logic                      fwd_part,
    output logic [WORD_W-1:0]         fwd_data,
    output logic                      err_now,
    output logic                      err_pend,
    output logic                      fill_done,
    output logic [ENTRIES-1:0]        line_valid,
    output logic [ENTRIES*WORD_W-1:0] line_data
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic             first_beat;
    logic             last_beat;
    logic             is_fetch;
    logic             has_first;
    logic             has_second;
    beat_verdict_t    verdict;
    logic             st_clear;
    logic             st_wr;
    logic             st_kill;
    logic [IDX_W-1:0] st_idx;

    lfc_seq #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .miss_valid (miss_valid),
        .miss_instr (miss_instr),
        .miss_addr  (miss_addr),
        .miss_len   (miss_len),
        .miss_ready (miss_ready),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .burst_req  (burst_req),
        .bus_data   (bus_data),
        .bus_term   (bus_term),
        .bus_err    (bus_err),
        .first_beat (first_beat),
        .last_beat  (last_beat),
        .is_fetch   (is_fetch),
        .has_first  (has_first),
        .has_second (has_second),
        .verdict    (verdict),
        .st_clear   (st_clear),
        .st_wr      (st_wr),
        .st_kill    (st_kill),
        .st_idx     (st_idx),
        .fwd_valid  (fwd_valid),
        .fwd_part   (fwd_part),
        .fwd_data   (fwd_data),
        .err_now    (err_now),
        .err_pend   (err_pend),
        .fill_done  (fill_done)
    );

    lfc_beat_eval u_eval (
        .first_beat (first_beat),
        .last_beat  (last_beat),
        .is_fetch   (is_fetch),
        .has_first  (has_first),
        .has_second (has_second),
        .ack        (burst_ack),
        .inhibit    (cache_inh),
        .fault      (bus_err),
        .verdict    (verdict)
    );

    lfc_line_store #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear_all (st_clear),
        .wr_en     (st_wr),
        .wr_idx    (st_idx),
        .wr_word   (bus_data),
        .kill_en   (st_kill),
        .kill_idx  (st_idx),
        .valid     (line_valid),
        .words     (line_data)
    );

endmodule

// File: rtl/lfc_checker.sv
`timescale 1ns/1ps
module lfc_checker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ENTRIES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               miss_ready,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rd,
    input logic               burst_req,
    input logic               bus_term,
    input logic               burst_ack,
    input logic               cache_inh,
    input logic               bus_err,
    input logic               fwd_valid,
    input logic               err_now,
    input logic               err_pend,
    input logic               fill_done,
    input logic [ENTRIES-1:0] line_valid
);

    p_req_within_read_r2: assert property (@(posedge clk) disable iff (rst)
        burst_req |-> bus_rd);

    p_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_term && !bus_err) |=> (bus_rd && $stable(bus_addr)));

    p_ack_drop_stops_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_term && !bus_err && !burst_ack) |=> !burst_req);

    p_inhibit_no_load_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_term && cache_inh && !bus_err) |=> $stable(line_valid));

    p_err_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(err_now && err_pend));

    p_fault_not_forwarded_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_err) |=> !fwd_valid);

    p_err_follows_fault_r10: assert property (@(posedge clk) disable iff (rst)
        (err_now || err_pend) |-> $past(bus_err && bus_rd));

    p_ready_only_idle_r11: assert property (@(posedge clk) disable iff (rst)
        miss_ready |-> !bus_rd);

    p_done_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> !fill_done);

endmodule

bind burst_fill_ctrl lfc_checker #(
    .ADDR_W  (ADDR_W),
    .ENTRIES (ENTRIES)
) u_lfc_checker (
    .clk        (clk),
    .rst        (rst),
    .miss_ready (miss_ready),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .burst_req  (burst_req),
    .bus_term   (bus_term),
    .burst_ack  (burst_ack),
    .cache_inh  (cache_inh),
    .bus_err    (bus_err),
    .fwd_valid  (fwd_valid),
    .err_now    (err_now),
    .err_pend   (err_pend),
    .fill_done  (fill_done),
    .line_valid (line_valid)
);

// File: tb/burst_fill_ctrl_bench.sv
`timescale 1ns/1ps
module burst_fill_ctrl_bench;

    localparam int K_FWD  = 0;
    localparam int K_NOW  = 1;
    localparam int K_PEND = 2;
    localparam int K_DONE = 3;

    localparam logic [1:0] OC_OK    = 2'd0;
    localparam logic [1:0] OC_NOACK = 2'd1;
    localparam logic [1:0] OC_INH   = 2'd2;
    localparam logic [1:0] OC_ERR   = 2'd3;

    logic         clk = 1'b0;
    logic         rst;
    logic         miss_valid, miss_instr;
    logic [31:0]  miss_addr;
    logic [2:0]   miss_len;
    logic         miss_ready;
    logic [31:0]  bus_addr;
    logic         bus_rd, burst_req;
    logic [31:0]  bus_data;
    logic         bus_term, burst_ack, cache_inh, bus_err;
    logic         fwd_valid, fwd_part;
    logic [31:0]  fwd_data;
    logic         err_now, err_pend, fill_done;
    logic [3:0]   line_valid;
    logic [127:0] line_data;

    always #2.5 clk = ~clk;

    burst_fill_ctrl u_burst_fill_ctrl (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_instr(miss_instr), .miss_addr(miss_addr),
        .miss_len(miss_len), .miss_ready(miss_ready),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .burst_req(burst_req),
        .bus_data(bus_data), .bus_term(bus_term), .burst_ack(burst_ack),
        .cache_inh(cache_inh), .bus_err(bus_err),
        .fwd_valid(fwd_valid), .fwd_part(fwd_part), .fwd_data(fwd_data),
        .err_now(err_now), .err_pend(err_pend), .fill_done(fill_done),
        .line_valid(line_valid), .line_data(line_data)
    );

    typedef struct {
        int          kind;
        logic        part;
        logic [31:0] data;
        string       rq;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    task automatic push(input int kind, input logic part, input logic [31:0] d, input string rq);
        exp_t e;
        e.kind = kind;
        e.part = part;
        e.data = d;
        e.rq   = rq;
        exp_q.push_back(e);
    endtask

    task automatic take(input int kind, input logic part, input logic [31:0] d);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R11", "unexpected output event", 32'(kind), 32'hFFFF_FFFF);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind, e.rq, "event kind", 32'(kind), 32'(e.kind));
            if (kind == K_FWD && e.kind == K_FWD) begin
                chk(e.part == part, e.rq, "forwarded part", {31'b0, part}, {31'b0, e.part});
                chk(e.data == d, e.rq, "forwarded data", d, e.data);
            end
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (fwd_valid) take(K_FWD, fwd_part, fwd_data);
            if (err_now)   take(K_NOW, 1'b0, 32'h0);
            if (err_pend)  take(K_PEND, 1'b0, 32'h0);
            if (fill_done) take(K_DONE, 1'b0, 32'h0);
        end
    end

    task automatic clear_bus();
        bus_term  = 1'b0;
        burst_ack = 1'b0;
        cache_inh = 1'b0;
        bus_err   = 1'b0;
        bus_data  = 32'h0;
    endtask

    task automatic apply(input logic [1:0] oc, input logic [31:0] d);
        bus_data  = d;
        bus_term  = (oc != OC_ERR);
        burst_ack = (oc != OC_NOACK);
        cache_inh = (oc == OC_INH);
        bus_err   = (oc == OC_ERR);
    endtask

    // Driver: one miss, beat outcomes in plan (2 bits per beat, beat 0 in [1:0])
    task automatic run_miss(input logic [31:0] a, input logic [2:0] len, input bit fetch,
                            input logic [7:0] plan, input logic [1:0] retry_oc,
                            input logic [23:0] seed, input string rq);
        logic [1:0]  idx0;
        bit          split;
        bit          p2in;
        logic [1:0]  p2idx;
        logic [3:0]  ev;
        logic [31:0] ed [4];
        bit          got2, fatal, stop, retry;
        logic [31:0] rd;
        idx0  = a[3:2];
        split = ({1'b0, a[1:0]} + {1'b0, len}) > 4'd4;
        p2in  = split && (idx0 != 2'd3);
        p2idx = idx0 + 2'd1;
        ev    = 4'h0;
        got2  = 0;
        fatal = 0;
        stop  = 0;
        for (int i = 0; i < 4; i++) ed[i] = 32'h0;

        @(negedge clk);
        chk(miss_ready, "R11", "ready before miss", {31'b0, miss_ready}, 32'd1);
        miss_valid = 1'b1;
        miss_addr  = a;
        miss_len   = len;
        miss_instr = fetch;
        @(negedge clk);
        miss_valid = 1'b0;
        chk(!miss_ready, "R11", "ready during fill", {31'b0, miss_ready}, 32'd0);

        for (int k = 0; k < 4 && !stop; k++) begin
            logic [1:0]  cur;
            logic [1:0]  oc;
            logic [31:0] d;
            cur = idx0 + k[1:0];
            oc  = plan[2*k +: 2];
            d   = {seed, 6'd0, cur};
            while (!bus_rd) @(negedge clk);
            chk(bus_addr == {a[31:4], cur, 2'b00}, "R2", "burst beat address",
                bus_addr, {a[31:4], cur, 2'b00});
            chk(burst_req == (k < 3), "R2", "burst request level",
                {31'b0, burst_req}, {31'b0, (k < 3)});
            case (oc)
                OC_ERR: begin
                    if (k == 0) begin
                        push(fetch ? K_PEND : K_NOW, 1'b0, 32'h0, rq);
                        fatal = 1;
                    end else begin
                        ev[cur] = 1'b0;
                    end
                    stop = 1;
                end
                OC_INH: begin
                    if (k == 0) push(K_FWD, 1'b0, d, rq);
                    else if (p2in && cur == p2idx) begin
                        push(K_FWD, 1'b1, d, rq);
                        got2 = 1;
                    end
                    stop = 1;
                end
                default: begin
                    ev[cur] = 1'b1;
                    ed[cur] = d;
                    if (k == 0) push(K_FWD, 1'b0, d, rq);
                    else if (p2in && cur == p2idx) begin
                        push(K_FWD, 1'b1, d, rq);
                        got2 = 1;
                    end
                    if (oc == OC_NOACK || k == 3) stop = 1;
                end
            endcase
            retry = split && !got2 && !fatal;
            if (stop && !retry) push(K_DONE, 1'b0, 32'h0, rq);
            apply(oc, d);
            @(negedge clk);
            clear_bus();
        end

        if (split && !got2 && !fatal) begin
            rd = {seed, 8'hEE};
            while (!bus_rd) @(negedge clk);
            chk(bus_addr == {a[31:2] + 30'd1, 2'b00}, "R9", "single read address",
                bus_addr, {a[31:2] + 30'd1, 2'b00});
            chk(!burst_req, "R9", "burst request low on single read",
                {31'b0, burst_req}, 32'd0);
            if (retry_oc == OC_ERR) push(fetch ? K_PEND : K_NOW, 1'b0, 32'h0, rq);
            else push(K_FWD, 1'b1, rd, rq);
            push(K_DONE, 1'b0, 32'h0, rq);
            apply(retry_oc, rd);
            @(negedge clk);
            clear_bus();
        end

        while (!fill_done) @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, rq, "outstanding expected events", 32'(exp_q.size()), 32'd0);
        chk(!fill_done, "R11", "done is one pulse", {31'b0, fill_done}, 32'd0);
        chk(!bus_rd, rq, "no further read after fill", {31'b0, bus_rd}, 32'd0);
        chk(line_valid == ev, rq, "line valid bits", {28'b0, line_valid}, {28'b0, ev});
        for (int e = 0; e < 4; e++) begin
            if (ev[e]) chk(line_data[32*e +: 32] == ed[e], rq, "line entry data",
                           line_data[32*e +: 32], ed[e]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        miss_valid = 1'b0;
        miss_instr = 1'b0;
        miss_addr  = 32'h0;
        miss_len   = 3'd4;
        clear_bus();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(miss_ready, "R1", "ready after reset", {31'b0, miss_ready}, 32'd1);
        chk(!bus_rd && !burst_req, "R1", "bus idle after reset", {30'b0, bus_rd, burst_req}, 32'd0);
        chk(!fwd_valid && !err_now && !err_pend && !fill_done, "R1", "pulses low after reset",
            {28'b0, fwd_valid, err_now, err_pend, fill_done}, 32'd0);
        chk(line_valid == 4'h0, "R1", "line invalid after reset", {28'b0, line_valid}, 32'd0);

        // R2, R3: full burst, wraparound from entry 1
        run_miss(32'h1000_0004, 3'd4, 1'b0, 8'h00, OC_OK, 24'h1A1A1A, "R3");
        // R4: acknowledge dropped on second beat, fetch
        run_miss(32'h2000_0008, 3'd2, 1'b1, 8'h04, OC_OK, 24'h2B2B2B, "R4");
        // R4: acknowledge dropped on first beat
        run_miss(32'h2100_0000, 3'd4, 1'b0, 8'h01, OC_OK, 24'h2C2C2C, "R4");
        // R5: inhibit on first beat
        run_miss(32'h3000_0000, 3'd4, 1'b0, 8'h02, OC_OK, 24'h3D3D3D, "R5");
        // R5 with R9: inhibit on first beat, operand spans into next line
        run_miss(32'h3100_000E, 3'd4, 1'b0, 8'h02, OC_OK, 24'h3E3E3E, "R9");
        // R6: inhibit on third beat
        run_miss(32'h4000_0000, 3'd4, 1'b0, 8'h20, OC_OK, 24'h4F4F4F, "R6");
        // R6: inhibit on the beat holding the operand remainder
        run_miss(32'h4100_0007, 3'd2, 1'b0, 8'h08, OC_OK, 24'h404040, "R6");
        // R7: first-beat error, data access
        run_miss(32'h5000_0004, 3'd4, 1'b0, 8'h03, OC_OK, 24'h515151, "R7");
        // R7: first-beat error, fetch, split operand: no single read
        run_miss(32'h5100_000D, 3'd4, 1'b1, 8'h03, OC_OK, 24'h525252, "R7");
        // R8: later-beat error, no flag
        run_miss(32'h6000_0008, 3'd4, 1'b0, 8'h30, OC_OK, 24'h636363, "R8");
        // R8 with R9: error on the remainder beat, single read succeeds
        run_miss(32'h6100_0001, 3'd4, 1'b0, 8'h0C, OC_OK, 24'h646464, "R9");
        // R10: single read errors, data access
        run_miss(32'h7000_0001, 3'd4, 1'b0, 8'h0C, OC_ERR, 24'h757575, "R10");
        // R10: single read errors, fetch
        run_miss(32'h7100_0006, 3'd4, 1'b1, 8'h0C, OC_ERR, 24'h767676, "R10");
        // R9: operand in last entry, full burst then single read in next line
        run_miss(32'h8000_000F, 3'd2, 1'b0, 8'h00, OC_OK, 24'h878787, "R9");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R11", "no stray events at end", 32'(exp_q.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule